// File: doc/BRIEF.md
# Density-Ordered Greedy SIMD-Set Co-Issue Packer

After a primary instruction has claimed some of the SIMD sets of an execution unit, this block fills the leftover sets with further work of the same unit type. Upstream logic has already qualified every candidate. A candidate is either an instruction from another warp (inter-warp) or an instruction of a divergent split held in one of the primary warp's two secondary instruction-buffer slots (intra-warp). Each candidate carries its warp, its kind, its slot, its split, its active-lane count and the number of sets it needs. The block keeps these candidates in one small pool. It orders the pool so that the work with the most lanes per set comes first, then walks the ordered pool and packs greedily.

The block runs in three phases. In the load phase candidates stream in over a valid/ready port. On the final beat the block also samples the current free-set count and the next-free-set pointer. An odd-even transposition network then sorts the pool in a fixed number of cycles. In the pack phase, every accepted candidate leaves as a record on a valid/ready output stream. The record tells the consumer the set range the candidate occupies and whether to free a secondary slot (intra) or step that warp's buffer (inter). When the consumer reports that an accepted split has become invalid, the block raises a flush request for the secondary half and its scoreboard, and it drops all remaining intra-warp work. A one-cycle done pulse closes the phase and presents the final count and pointer.

Back-pressure: a candidate beat transfers on a clock edge where cand_valid and cand_ready are both high. cand_ready is high only in the load phase. An accept record transfers when acc_valid and acc_ready are both high. While acc_ready is low, acc_valid and all record fields hold. Every pack must contain at least one candidate, and every candidate needs at least one set.

Top module: `coissue_packer`

## Requirements
- R1: After reset cand_ready is high. It stays high until the beat that carries cand_last, or the beat that fills the 8-entry pool, and it then stays low until the pack phase ends.
- R2: Candidate a is packed before b when a.active × b.sets > b.active × a.sets, which is the comparison of active lanes per set without a divider.
- R3: At equal density, the higher active count goes first, then the lower warp id. Candidates that tie on all three keep their arrival order.
- R4: The pool is visited in sorted order, and visiting stops once the free-set count is zero. With a free count of zero, no record is produced.
- R5: A candidate whose sets needed exceed the current free count is skipped, and later candidates are still tried.
- R6: Each record carries the candidate's warp, kind (acc_intra=1: free slot acc_slot; 0: step warp acc_warp's buffer), slot, split, active count and sets. acc_base equals the pointer before the accept. The free count then drops by the sets needed and the pointer rises by the same amount.
- R7: split_inv is sampled in the cycle after each intra-warp accept. If it is high, flush_req is high in that cycle with flush_warp set to that warp, and no further intra-warp record follows in this pack. Inter-warp records continue.
- R8: While acc_valid is high and acc_ready low, acc_valid and all record fields are held.
- R9: After reset acc_valid, flush_req and done are low. At the end of each pack, done is high for exactly one cycle, with free_sets_out and free_ptr_out giving the final count and pointer.
- R10: free_sets_in and free_ptr_in are used only as sampled on the final load beat. Their values on earlier beats have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Candidate beat valid |
| cand_ready | output | 1 | Pool can take a candidate |
| cand_last | input | 1 | Final candidate of this pack |
| cand_warp | input | 5 | Warp id |
| cand_intra | input | 1 | 1 = secondary-slot split of the primary warp |
| cand_slot | input | 2 | Secondary slot (2 or 3) for intra candidates |
| cand_split | input | 4 | Split id |
| cand_active | input | 6 | Active lanes |
| cand_sets | input | 4 | SIMD sets needed (1 or more) |
| free_sets_in | input | 4 | Free-set count, sampled on the final beat |
| free_ptr_in | input | 4 | Next-free-set pointer, sampled on the final beat |
| acc_valid | output | 1 | Accept record valid |
| acc_ready | input | 1 | Consumer takes the record |
| acc_warp | output | 5 | Accepted warp |
| acc_intra | output | 1 | Accepted kind |
| acc_slot | output | 2 | Slot to free when intra |
| acc_split | output | 4 | Split id |
| acc_active | output | 6 | Active lanes |
| acc_sets | output | 4 | Sets occupied |
| acc_base | output | 4 | First set of the placement |
| split_inv | input | 1 | Accepted split became invalid (cycle after an intra accept) |
| flush_req | output | 1 | Flush secondary half and clear secondary scoreboard |
| flush_warp | output | 5 | Warp to flush |
| done | output | 1 | Pack finished (one cycle) |
| free_sets_out | output | 4 | Final free count |
| free_ptr_out | output | 4 | Final next-free pointer |

## Verification
The hardest state to reach is the purge. It needs an intra-warp accept whose split is reported invalid while a second intra candidate is still waiting further down the sorted pool and inter-warp work follows it. A directed case sets this up: two secondary-slot candidates of equal density ahead of an inter-warp one, with the invalidation driven in the sampling cycle. Randomised packs then mix intra positions, invalidation choices and random consumer stalls. Tie-break ordering and the free-set exhaustion edges are also hit by directed packs.

// File: rtl/coissue_pack_pkg.sv
package coissue_pack_pkg;
  localparam int WARP_W  = 5;
  localparam int SPLIT_W = 4;
  localparam int ACT_W   = 6;
  localparam int SETS_W  = 4;
  localparam int SLOT_W  = 2;
  localparam int PROD_W  = ACT_W + SETS_W;

  typedef struct packed {
    logic               vld;
    logic               intra;
    logic [SLOT_W-1:0]  slot;
    logic [WARP_W-1:0]  warp;
    logic [SPLIT_W-1:0] split;
    logic [ACT_W-1:0]   act;
    logic [SETS_W-1:0]  sets;
  } cand_t;

  // True when a must be packed ahead of b (strict: ties return 0).
  function automatic logic ranks_before(cand_t a, cand_t b);
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    lhs = PROD_W'(a.act) * PROD_W'(b.sets);
    rhs = PROD_W'(b.act) * PROD_W'(a.sets);
    if (!a.vld) return 1'b0;
    if (!b.vld) return 1'b1;
    if (lhs != rhs) return lhs > rhs;
    if (a.act != b.act) return a.act > b.act;
    return a.warp < b.warp;
  endfunction
endpackage

// File: rtl/coissue_pool_sorter.sv
module coissue_pool_sorter
  import coissue_pack_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cand_valid,
  output logic                  cand_ready,
  input  logic                  cand_last,
  input  cand_t                 cand_in,
  output logic                  load_end,
  output logic                  sort_done,
  input  logic                  pack_done,
  output cand_t [DEPTH-1:0]     pool
);
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam int SEL_W = $clog2(DEPTH);
  localparam int PH_W  = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {SO_LOAD, SO_SORT, SO_HOLD} so_state_e;

  so_state_e          st;
  cand_t [DEPTH-1:0]  ent;
  cand_t [DEPTH-1:0]  nxt;
  logic [IDX_W-1:0]   cnt;
  logic [PH_W-1:0]    phase;

  assign cand_ready = (st == SO_LOAD);
  assign load_end   = cand_valid && cand_ready &&
                      (cand_last || cnt == IDX_W'(DEPTH - 1));
  assign sort_done  = (st == SO_SORT) && (phase == PH_W'(DEPTH - 1));
  assign pool       = ent;

  // One transposition phase: even phases pair (0,1),(2,3)..., odd (1,2),...
  always_comb begin
    nxt = ent;
    for (int k = 0; k < DEPTH - 1; k++) begin
      if ((k % 2) == int'(phase[0])) begin
        if (ranks_before(ent[k+1], ent[k])) begin
          nxt[k]   = ent[k+1];
          nxt[k+1] = ent[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SO_LOAD;
      ent   <= '0;
      cnt   <= '0;
      phase <= '0;
    end else begin
      case (st)
        SO_LOAD: begin
          if (cand_valid) begin
            ent[cnt[SEL_W-1:0]] <= cand_in;
            cnt <= cnt + 1'b1;
            if (load_end) begin
              st    <= SO_SORT;
              phase <= '0;
            end
          end
        end
        SO_SORT: begin
          ent   <= nxt;
          phase <= phase + 1'b1;
          if (sort_done) st <= SO_HOLD;
        end
        SO_HOLD: begin
          if (pack_done) begin
            ent <= '0;
            cnt <= '0;
            st  <= SO_LOAD;
          end
        end
        default: st <= SO_LOAD;
      endcase
    end
  end

  p_pool_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cand_ready |-> cnt < IDX_W'(DEPTH));

  p_load_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> !cand_ready);

  generate
    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_order_chk
      p_sorted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SO_HOLD) |-> !ranks_before(ent[i+1], ent[i]));
    end
  endgenerate
endmodule

// File: rtl/coissue_pack_walk.sv
module coissue_pack_walk
  import coissue_pack_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cand_t [DEPTH-1:0]    pool,
  input  logic                 grab,
  input  logic [SETS_W-1:0]    grab_free,
  input  logic [SETS_W-1:0]    grab_ptr,
  input  logic                 start,
  output logic                 acc_valid,
  input  logic                 acc_ready,
  output logic [WARP_W-1:0]    acc_warp,
  output logic                 acc_intra,
  output logic [SLOT_W-1:0]    acc_slot,
  output logic [SPLIT_W-1:0]   acc_split,
  output logic [ACT_W-1:0]     acc_active,
  output logic [SETS_W-1:0]    acc_sets,
  output logic [SETS_W-1:0]    acc_base,
  input  logic                 split_inv,
  output logic                 flush_req,
  output logic [WARP_W-1:0]    flush_warp,
  output logic                 done,
  output logic [SETS_W-1:0]    free_sets_out,
  output logic [SETS_W-1:0]    free_ptr_out
);
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam int SEL_W = $clog2(DEPTH);

  typedef enum logic [1:0] {PK_IDLE, PK_SCAN, PK_CHECK, PK_DONE} pk_state_e;

  pk_state_e          st;
  logic [IDX_W-1:0]   idx;
  logic [SETS_W-1:0]  free_cnt;
  logic [SETS_W-1:0]  free_ptr;
  logic               purge;
  logic [WARP_W-1:0]  last_warp;
  cand_t              cur;
  logic               at_end;
  logic               skip;

  always_comb begin
    cur    = (idx < IDX_W'(DEPTH)) ? pool[idx[SEL_W-1:0]] : '0;
    at_end = !cur.vld;
    skip   = (cur.intra && purge) || (cur.sets > free_cnt);
  end

  assign acc_valid     = (st == PK_SCAN) && !at_end && (free_cnt != '0) && !skip;
  assign acc_warp      = cur.warp;
  assign acc_intra     = cur.intra;
  assign acc_slot      = cur.slot;
  assign acc_split     = cur.split;
  assign acc_active    = cur.act;
  assign acc_sets      = cur.sets;
  assign acc_base      = free_ptr;
  assign flush_req     = (st == PK_CHECK) && split_inv;
  assign flush_warp    = last_warp;
  assign done          = (st == PK_DONE);
  assign free_sets_out = free_cnt;
  assign free_ptr_out  = free_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= PK_IDLE;
      idx       <= '0;
      free_cnt  <= '0;
      free_ptr  <= '0;
      purge     <= 1'b0;
      last_warp <= '0;
    end else begin
      case (st)
        PK_IDLE: begin
          if (grab) begin
            free_cnt <= grab_free;
            free_ptr <= grab_ptr;
          end
          if (start) begin
            st    <= PK_SCAN;
            idx   <= '0;
            purge <= 1'b0;
          end
        end
        PK_SCAN: begin
          if (at_end || free_cnt == '0) begin
            st <= PK_DONE;
          end else if (skip) begin
            idx <= idx + 1'b1;
          end else if (acc_ready) begin
            free_cnt <= free_cnt - cur.sets;
            free_ptr <= free_ptr + cur.sets;
            idx      <= idx + 1'b1;
            if (cur.intra) begin
              st        <= PK_CHECK;
              last_warp <= cur.warp;
            end
          end
        end
        PK_CHECK: begin
          if (split_inv) purge <= 1'b1;
          st <= PK_SCAN;
        end
        PK_DONE: st <= PK_IDLE;
        default: st <= PK_IDLE;
      endcase
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid &&
      $stable({acc_warp, acc_intra, acc_slot, acc_split, acc_active, acc_sets, acc_base}));

  p_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_sets <= free_sets_out) && (free_sets_out != '0));

  p_flush_after_intra_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(acc_valid && acc_ready && acc_intra));

  p_no_intra_after_purge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PK_SCAN) && purge |-> !(acc_valid && acc_intra));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> free_ptr_out == $past(acc_base + acc_sets));
endmodule

// File: rtl/coissue_packer.sv
module coissue_packer
  import coissue_pack_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cand_valid,
  output logic        cand_ready,
  input  logic        cand_last,
  input  logic [4:0]  cand_warp,
  input  logic        cand_intra,
  input  logic [1:0]  cand_slot,
  input  logic [3:0]  cand_split,
  input  logic [5:0]  cand_active,
  input  logic [3:0]  cand_sets,
  input  logic [3:0]  free_sets_in,
  input  logic [3:0]  free_ptr_in,
  output logic        acc_valid,
  input  logic        acc_ready,
  output logic [4:0]  acc_warp,
  output logic        acc_intra,
  output logic [1:0]  acc_slot,
  output logic [3:0]  acc_split,
  output logic [5:0]  acc_active,
  output logic [3:0]  acc_sets,
  output logic [3:0]  acc_base,
  input  logic        split_inv,
  output logic        flush_req,
  output logic [4:0]  flush_warp,
  output logic        done,
  output logic [3:0]  free_sets_out,
  output logic [3:0]  free_ptr_out
);
  cand_t             cand_in;
  cand_t [DEPTH-1:0] pool;
  logic              load_end;
  logic              sort_done;

  always_comb begin
    cand_in.vld   = 1'b1;
    cand_in.intra = cand_intra;
    cand_in.slot  = cand_slot;
    cand_in.warp  = cand_warp;
    cand_in.split = cand_split;
    cand_in.act   = cand_active;
    cand_in.sets  = cand_sets;
  end

  coissue_pool_sorter #(.DEPTH(DEPTH)) u_sorter (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_valid (cand_valid),
    .cand_ready (cand_ready),
    .cand_last  (cand_last),
    .cand_in    (cand_in),
    .load_end   (load_end),
    .sort_done  (sort_done),
    .pack_done  (done),
    .pool       (pool)
  );

  coissue_pack_walk #(.DEPTH(DEPTH)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pool          (pool),
    .grab          (load_end),
    .grab_free     (free_sets_in),
    .grab_ptr      (free_ptr_in),
    .start         (sort_done),
    .acc_valid     (acc_valid),
    .acc_ready     (acc_ready),
    .acc_warp      (acc_warp),
    .acc_intra     (acc_intra),
    .acc_slot      (acc_slot),
    .acc_split     (acc_split),
    .acc_active    (acc_active),
    .acc_sets      (acc_sets),
    .acc_base      (acc_base),
    .split_inv     (split_inv),
    .flush_req     (flush_req),
    .flush_warp    (flush_warp),
    .done          (done),
    .free_sets_out (free_sets_out),
    .free_ptr_out  (free_ptr_out)
  );
endmodule

// File: tb/coissue_packer_bench.sv
`timescale 1ns/1ps
module coissue_packer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cand_valid = 1'b0, cand_last = 1'b0, cand_intra = 1'b0;
  logic [4:0] cand_warp = '0;
  logic [1:0] cand_slot = '0;
  logic [3:0] cand_split = '0, cand_sets = '0, free_sets_in = '0, free_ptr_in = '0;
  logic [5:0] cand_active = '0;
  logic acc_ready = 1'b0, split_inv = 1'b0;
  logic cand_ready, acc_valid, acc_intra, flush_req, done;
  logic [4:0] acc_warp, flush_warp;
  logic [1:0] acc_slot;
  logic [3:0] acc_split, acc_sets, acc_base, free_sets_out, free_ptr_out;
  logic [5:0] acc_active;

  always #2.5 clk = ~clk;

  coissue_packer u_coissue_packer (.*);

  int checks = 0, errors = 0, cycles = 0;
  int c_warp[8], c_intra[8], c_slot[8], c_split[8], c_act[8], c_sets[8];
  int n_c, f_in, p_in, prim;
  bit inv_plan[2];
  int x_idx[8], x_base[8], n_x, x_free, x_ptr, x_flush;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit rb(int a, int b);
    if (c_act[a] * c_sets[b] != c_act[b] * c_sets[a])
      return c_act[a] * c_sets[b] > c_act[b] * c_sets[a];
    if (c_act[a] != c_act[b]) return c_act[a] > c_act[b];
    return c_warp[a] < c_warp[b];
  endfunction

  task automatic build_expect();
    int ord[8];
    int fr, pt, k;
    bit pg;
    for (int i = 0; i < n_c; i++) ord[i] = i;
    for (int i = 1; i < n_c; i++)
      for (int j = i; j > 0 && rb(ord[j], ord[j-1]); j--) begin
        int t = ord[j]; ord[j] = ord[j-1]; ord[j-1] = t;
      end
    fr = f_in; pt = p_in; pg = 0; k = 0; n_x = 0; x_flush = 0;
    for (int i = 0; i < n_c; i++) begin
      int id = ord[i];
      if (fr == 0) break;
      if (c_intra[id] != 0 && pg) continue;
      if (c_sets[id] > fr) continue;
      x_idx[n_x] = id; x_base[n_x] = pt; n_x++;
      fr -= c_sets[id]; pt += c_sets[id];
      if (c_intra[id] != 0) begin
        if (inv_plan[k]) begin pg = 1; x_flush++; end
        k++;
      end
    end
    x_free = fr; x_ptr = pt;
  endtask

  task automatic run_case(string tag);
    int got, fl, ki;
    bit fin, stall;
    logic [29:0] saved;
    build_expect();
    for (int i = 0; i < n_c; i++) begin
      @(negedge clk);
      cand_valid = 1; cand_last = (i == n_c - 1);
      cand_warp = 5'(c_warp[i]); cand_intra = c_intra[i] != 0;
      cand_slot = 2'(c_slot[i]); cand_split = 4'(c_split[i]);
      cand_active = 6'(c_act[i]); cand_sets = 4'(c_sets[i]);
      // R10: only the final beat's free count/pointer may matter
      free_sets_in = cand_last ? 4'(f_in) : 4'($urandom);
      free_ptr_in  = cand_last ? 4'(p_in) : 4'($urandom);
      while (!cand_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    cand_valid = 0; cand_last = 0;
    got = 0; fl = 0; ki = 0; fin = 0; stall = 0; saved = '0;
    for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (stall)
        chk(acc_valid && saved == {acc_warp, acc_intra, acc_slot, acc_split, acc_active, acc_sets, acc_base},
            {tag, " R8 held record"}, int'(acc_valid), 1);
      acc_ready = ($urandom % 4) != 0;
      stall = acc_valid && !acc_ready;
      saved = {acc_warp, acc_intra, acc_slot, acc_split, acc_active, acc_sets, acc_base};
      if (acc_valid && acc_ready) begin
        if (got < n_x) begin
          int id = x_idx[got];
          chk(acc_warp == 5'(c_warp[id]) && acc_intra == (c_intra[id] != 0) &&
              acc_slot == 2'(c_slot[id]) && acc_split == 4'(c_split[id]) &&
              acc_active == 6'(c_act[id]),
              {tag, " R2/R3/R4 record order"}, int'(acc_warp), c_warp[id]);
          chk(acc_sets == 4'(c_sets[id]) && acc_base == 4'(x_base[got]),
              {tag, " R6 placement"}, int'(acc_base), x_base[got]);
        end else chk(0, {tag, " R4 extra record"}, got + 1, n_x);
        if (acc_intra) begin split_inv = (ki < 2) ? inv_plan[ki] : 1'b0; ki++; end
        got++;
      end
      if (flush_req) begin
        fl++;
        chk(flush_warp == 5'(prim), {tag, " R7 flush warp"}, int'(flush_warp), prim);
      end
      if (done) begin
        fin = 1;
        chk(got == n_x, {tag, " R4/R5 record count"}, got, n_x);
        chk(fl == x_flush, {tag, " R7 flush count"}, fl, x_flush);
        chk(free_sets_out == 4'(x_free), {tag, " R9/R10 final free"}, int'(free_sets_out), x_free);
        chk(free_ptr_out == 4'(x_ptr), {tag, " R9/R10 final pointer"}, int'(free_ptr_out), x_ptr);
      end
    end
    chk(fin, {tag, " R9 done seen"}, int'(fin), 1);
    acc_ready = 0; split_inv = 0;
    @(negedge clk);
    chk(!done && cand_ready == 1'b1, {tag, " R1/R9 back to load"}, int'(cand_ready), 1);
  endtask

  task automatic setc(int i, int w, int in, int sl, int sp, int a, int s);
    c_warp[i] = w; c_intra[i] = in; c_slot[i] = sl; c_split[i] = sp; c_act[i] = a; c_sets[i] = s;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cand_ready == 1'b1, "R1 reset ready", int'(cand_ready), 1);
    chk(!acc_valid && !done && !flush_req, "R9 reset outputs", int'(acc_valid), 0);

    // R3 tie-breaks: density 6 first, then act8 warp2 before act8 warp3, then act4
    prim = 0; inv_plan = '{0, 0}; n_c = 4; f_in = 8; p_in = 0;
    setc(0, 3, 0, 0, 1, 8, 2); setc(1, 1, 0, 0, 2, 4, 1);
    setc(2, 2, 0, 0, 3, 8, 2); setc(3, 5, 0, 0, 4, 6, 1);
    run_case("tie");

    // R7 purge: slot2 accepted and invalidated, slot3 dropped, inter still packed
    prim = 7; inv_plan = '{1, 0}; n_c = 3; f_in = 8; p_in = 0;
    setc(0, 9, 0, 0, 0, 4, 1); setc(1, 7, 1, 3, 5, 8, 1); setc(2, 7, 1, 2, 6, 16, 2);
    run_case("purge");

    // R5 skip: big candidate does not fit, smaller ones fill to zero
    prim = 0; inv_plan = '{0, 0}; n_c = 3; f_in = 3; p_in = 5;
    setc(0, 1, 0, 0, 0, 32, 8); setc(1, 2, 0, 0, 0, 6, 2); setc(2, 3, 0, 0, 0, 2, 1);
    run_case("skip");

    // R4 free count zero: nothing accepted
    prim = 0; n_c = 2; f_in = 0; p_in = 8;
    setc(0, 1, 0, 0, 0, 10, 1); setc(1, 2, 0, 0, 0, 3, 1);
    run_case("nofree");

    // R3 full tie of two intra entries keeps arrival order
    prim = 4; inv_plan = '{0, 0}; n_c = 2; f_in = 8; p_in = 0;
    setc(0, 4, 1, 3, 1, 12, 3); setc(1, 4, 1, 2, 2, 12, 3);
    run_case("stable");

    for (int r = 0; r < 60; r++) begin
      int ni;
      prim = $urandom % 32; n_c = 1 + $urandom % 8; f_in = $urandom % 9;
      p_in = $urandom % (9 - f_in); ni = 0;
      inv_plan[0] = $urandom % 2; inv_plan[1] = $urandom % 2;
      for (int i = 0; i < n_c; i++) begin
        if (($urandom % 3 == 0) && ni < 2) begin
          setc(i, prim, 1, 2 + ni, $urandom % 16, 1 + $urandom % 32, 1 + $urandom % 8);
          ni++;
        end else
          setc(i, (prim + 1 + i) % 32, 0, 0, $urandom % 16, 1 + $urandom % 32, 1 + $urandom % 8);
      end
      run_case("rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule